// File: doc/BRIEF.md
# Floating-Point to Signed Integer Converter

This block turns one IEEE-754 binary32 or binary64 value into a two's-complement integer of 32 or 64 bits. The caller picks the operation on each request: a plain conversion that follows the rounding mode supplied by the control path, or one of four operations that fix their own direction. Those four are round to nearest-even, truncate toward zero, ceiling toward plus infinity and floor toward minus infinity. The forced direction applies only to that request. It does not change the mode that later plain conversions use.

A request is taken on any clock where `in_valid` is high. The result and three flags appear on the next clock, marked by a one-cycle `out_valid` pulse. When the operand is not a number, or its rounded value does not fit the chosen width, the result is replaced by the largest positive integer of that width whatever the input sign. A 32-bit result is returned sign-extended to 64 bits.

Top module: `fp2int_conv`

## Requirements
- R1: Plain conversion (`in_op`=0, and the unused codes 5 to 7) rounds with `in_rmode`, which is encoded as 0 nearest-even, 1 toward zero, 2 toward plus infinity and 3 toward minus infinity.
- R2: The round operation (`in_op`=1) always rounds to nearest, with ties going to the even integer, whatever `in_rmode` holds.
- R3: Truncate (`in_op`=2) rounds toward zero, ceiling (`in_op`=3) rounds toward plus infinity and floor (`in_op`=4) rounds toward minus infinity, whatever `in_rmode` holds.
- R4: An infinity or NaN operand raises `out_invalid` and returns 0x7FFFFFFF for a 32-bit result or 0x7FFFFFFFFFFFFFFF for a 64-bit result, with the other two flags low.
- R5: A finite operand whose rounded value lies outside the signed range of the chosen width raises `out_overflow` and returns the same largest-positive pattern, with inexact and invalid low. The most negative value of each width converts without a flag.
- R6: `out_inexact` is high exactly when the operand has a nonzero fraction that rounding discards and neither invalid nor overflow is raised. Exact values, including both signed zeros, give result 0 or the exact integer with no flag.
- R7: Subnormal operands (exponent field zero, fraction nonzero) round as tiny values: to 0 under nearest-even and toward zero, to +1 or -1 when the direction points away from zero, and they always raise inexact.
- R8: `in_is_double`=1 takes binary64 from all 64 operand bits. `in_is_double`=0 takes binary32 from bits 31:0 and ignores bits 63:32. Both precisions feed both result widths.
- R9: With `in_wide`=0 the 32-bit result sits in bits 31:0 and bits 63:32 copy bit 31. With `in_wide`=1 all 64 bits carry the result.
- R10: `out_valid` is high on the clock after each clock with `in_valid` high and low otherwise. Result and flags hold their values while no request arrives.
- R11: A forced-direction operation leaves no trace: a following plain conversion with the same `in_rmode` rounds by that mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request strobe |
| in_operand | input | 64 | Floating-point operand (binary32 in bits 31:0) |
| in_is_double | input | 1 | 1 = binary64 operand, 0 = binary32 |
| in_wide | input | 1 | 1 = 64-bit result, 0 = 32-bit result |
| in_op | input | 3 | 0 convert, 1 round, 2 truncate, 3 ceiling, 4 floor |
| in_rmode | input | 2 | Rounding mode used by plain conversion |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| out_result | output | 64 | Signed integer result |
| out_inexact | output | 1 | Fraction discarded |
| out_overflow | output | 1 | Finite value out of range |
| out_invalid | output | 1 | NaN or infinity operand |

## Verification
The block keeps no state between requests apart from the output register, so any internal fault shows on the very next `out_valid` pulse. A wrong choice of direction shows as a result that is off by one near halfway and signed values. A wrong range limit shows as a missing or spurious overflow at the edges of each width. A broken sign extension or saturation pattern shows in the upper word of the result. The directed cases therefore sit on ties, on the signed boundaries of both widths, on subnormals and on special encodings, and each is compared on the cycle its strobe rises.

// File: rtl/fp2int_conv.sv
module fp2int_conv (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [63:0] in_operand,
  input  logic        in_is_double,
  input  logic        in_wide,
  input  logic [2:0]  in_op,
  input  logic [1:0]  in_rmode,
  output logic        out_valid,
  output logic [63:0] out_result,
  output logic        out_inexact,
  output logic        out_overflow,
  output logic        out_invalid
);

  localparam int FRAC_W = 52;
  localparam int INT_W  = 65;
  localparam int SH_W   = INT_W + FRAC_W + 1;

  logic               sgn, exp_max, exp_zero, frac_nz;
  logic [FRAC_W-1:0]  frac;
  logic signed [12:0] unb;
  logic               is_zero, is_tiny, is_big;
  logic [6:0]         shamt;
  logic [SH_W-1:0]    sh;
  logic [INT_W-1:0]   ipart;
  logic               rbit, stk, inc;
  logic [1:0]         dir;
  logic [INT_W:0]     mag, lim;
  logic               ovf, inx;
  logic [63:0]        sval, res, sat;

  assign sgn      = in_is_double ? in_operand[63] : in_operand[31];
  assign frac     = in_is_double ? in_operand[51:0] : {in_operand[22:0], 29'b0};
  assign exp_max  = in_is_double ? (&in_operand[62:52]) : (&in_operand[30:23]);
  assign exp_zero = in_is_double ? ~(|in_operand[62:52]) : ~(|in_operand[30:23]);
  assign frac_nz  = |frac;
  assign unb      = in_is_double ? $signed({2'b00, in_operand[62:52]}) - 13'sd1023
                                 : $signed({5'b00000, in_operand[30:23]}) - 13'sd127;

  assign is_zero = exp_zero & ~frac_nz;
  assign is_tiny = (exp_zero & frac_nz) | (~exp_zero & ~exp_max & (unb < -13'sd1));
  assign is_big  = ~exp_zero & ~exp_max & (unb > 13'sd63);
  assign shamt   = 7'(unb + 13'sd1);
  assign sh      = {{INT_W{1'b0}}, 1'b1, frac} << shamt;

  always_comb begin
    ipart = sh[SH_W-1:FRAC_W+1];
    rbit  = sh[FRAC_W];
    stk   = |sh[FRAC_W-1:0];
    if (is_zero | exp_max | is_big) begin
      ipart = '0; rbit = 1'b0; stk = 1'b0;
    end else if (is_tiny) begin
      ipart = '0; rbit = 1'b0; stk = 1'b1;
    end
  end

  always_comb begin
    case (in_op)
      3'd1:    dir = 2'd0;
      3'd2:    dir = 2'd1;
      3'd3:    dir = 2'd2;
      3'd4:    dir = 2'd3;
      default: dir = in_rmode;
    endcase
    case (dir)
      2'd0:    inc = rbit & (stk | ipart[0]);
      2'd1:    inc = 1'b0;
      2'd2:    inc = (rbit | stk) & ~sgn;
      default: inc = (rbit | stk) & sgn;
    endcase
  end

  assign mag  = {1'b0, ipart} + {{INT_W{1'b0}}, inc};
  assign lim  = (in_wide ? (66'd1 << 63) : (66'd1 << 31)) - {65'd0, ~sgn};
  assign ovf  = ~exp_max & (is_big | (mag > lim));
  assign inx  = ~exp_max & ~ovf & (rbit | stk);
  assign sval = sgn ? -mag[63:0] : mag[63:0];
  assign sat  = in_wide ? 64'h7FFF_FFFF_FFFF_FFFF : 64'h0000_0000_7FFF_FFFF;
  assign res  = (exp_max | ovf) ? sat
              : (in_wide ? sval : {{32{sval[31]}}, sval[31:0]});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_result   <= '0;
      out_inexact  <= 1'b0;
      out_overflow <= 1'b0;
      out_invalid  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_result   <= res;
        out_inexact  <= inx;
        out_overflow <= ovf;
        out_invalid  <= exp_max;
      end
    end
  end

endmodule

// File: rtl/fp2int_conv_chk.sv
module fp2int_conv_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [63:0] in_operand,
  input logic        in_is_double,
  input logic        in_wide,
  input logic [2:0]  in_op,
  input logic [1:0]  in_rmode,
  input logic        out_valid,
  input logic [63:0] out_result,
  input logic        out_inexact,
  input logic        out_overflow,
  input logic        out_invalid
);

  assert_valid_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_valid_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_result)));

  assert_invalid_special_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (in_is_double ? (&in_operand[62:52]) : (&in_operand[30:23])))
      |=> (out_invalid && !out_overflow && !out_inexact));

  assert_saturate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_wide) ##1 (out_overflow || out_invalid)
      |-> out_result == 64'h0000_0000_7FFF_FFFF);

  assert_saturate_wide_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_wide) ##1 (out_overflow || out_invalid)
      |-> out_result == 64'h7FFF_FFFF_FFFF_FFFF);

  assert_flag_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $countones({out_inexact, out_overflow, out_invalid}) <= 1);

  assert_sign_extend_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_wide) |=> out_result[63:32] == {32{out_result[31]}});

endmodule

bind fp2int_conv fp2int_conv_chk u_chk (.*);

// File: tb/fp2int_conv_tb.sv
`timescale 1ns/1ps
module fp2int_conv_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] in_operand = '0;
  logic        in_is_double = 1'b0;
  logic        in_wide = 1'b0;
  logic [2:0]  in_op = '0;
  logic [1:0]  in_rmode = '0;
  logic        out_valid;
  logic [63:0] out_result;
  logic        out_inexact, out_overflow, out_invalid;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  localparam logic [2:0] NO = 3'b000, IX = 3'b100, OV = 3'b010, IV = 3'b001;
  localparam logic [63:0] S32 = 64'h0000_0000_7FFF_FFFF;
  localparam logic [63:0] S64 = 64'h7FFF_FFFF_FFFF_FFFF;

  always #10 clk = ~clk;

  fp2int_conv u_dut (.*);

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // flags compared as {inexact, overflow, invalid}
  task automatic conv(input string tag, input logic [63:0] opd, input logic dbl, input logic wide,
                      input logic [2:0] op, input logic [1:0] rm,
                      input logic [63:0] exp_res, input logic [2:0] exp_fl);
    @(negedge clk);
    in_valid = 1'b1; in_operand = opd; in_is_double = dbl;
    in_wide = wide; in_op = op; in_rmode = rm;
    @(negedge clk);
    in_valid = 1'b0;
    check({tag, " valid"}, {63'd0, out_valid}, 64'd1);
    check({tag, " result"}, out_result, exp_res);
    check({tag, " flags"}, {61'd0, out_inexact, out_overflow, out_invalid}, {61'd0, exp_fl});
  endtask

  task automatic t_reset;
    check("R10 reset valid", {63'd0, out_valid}, 64'd0);
    check("R10 reset result", out_result, 64'd0);
    check("R10 reset flags", {61'd0, out_inexact, out_overflow, out_invalid}, 64'd0);
  endtask

  task automatic t_convert_modes;
    conv("R1 1.5 rm0", 64'h3FF8000000000000, 1, 1, 0, 0, 64'd2, IX);
    conv("R1 1.5 rm1", 64'h3FF8000000000000, 1, 1, 0, 1, 64'd1, IX);
    conv("R1 1.5 rm2", 64'h3FF8000000000000, 1, 1, 0, 2, 64'd2, IX);
    conv("R1 1.5 rm3", 64'h3FF8000000000000, 1, 1, 0, 3, 64'd1, IX);
    conv("R1 -1.5f rm3", 64'h00000000BFC00000, 0, 1, 0, 3, 64'hFFFF_FFFF_FFFF_FFFE, IX);
    conv("R1 -1.5f rm2", 64'h00000000BFC00000, 0, 1, 0, 2, 64'hFFFF_FFFF_FFFF_FFFF, IX);
    conv("R1 2.5 op7 rm0", 64'h4004000000000000, 1, 1, 7, 0, 64'd2, IX);
  endtask

  task automatic t_round;
    conv("R2 round 2.5 rm2", 64'h4004000000000000, 1, 1, 1, 2, 64'd2, IX);
    conv("R2 round 3.5 rm3", 64'h400C000000000000, 1, 1, 1, 3, 64'd4, IX);
    conv("R2 round -2.5 rm2", 64'hC004000000000000, 1, 1, 1, 2, 64'hFFFF_FFFF_FFFF_FFFE, IX);
    conv("R2 round 0.3 rm2", 64'h3FD3333333333333, 1, 1, 1, 2, 64'd0, IX);
  endtask

  task automatic t_directed;
    conv("R3 trunc 2.5 rm0", 64'h4004000000000000, 1, 1, 2, 0, 64'd2, IX);
    conv("R3 trunc -2.5 rm3", 64'hC004000000000000, 1, 1, 2, 3, 64'hFFFF_FFFF_FFFF_FFFE, IX);
    conv("R3 ceil 2.5 rm3", 64'h4004000000000000, 1, 1, 3, 3, 64'd3, IX);
    conv("R3 ceil -2.5 rm3", 64'hC004000000000000, 1, 1, 3, 3, 64'hFFFF_FFFF_FFFF_FFFE, IX);
    conv("R3 floor 2.5 rm2", 64'h4004000000000000, 1, 1, 4, 2, 64'd2, IX);
    conv("R3 floor -0.3 rm0", 64'hBFD3333333333333, 1, 1, 4, 0, 64'hFFFF_FFFF_FFFF_FFFF, IX);
    conv("R3 ceil -0.3 rm3", 64'hBFD3333333333333, 1, 1, 3, 3, 64'd0, IX);
  endtask

  task automatic t_invalid;
    conv("R4 +inf wide", 64'h7FF0000000000000, 1, 1, 0, 0, S64, IV);
    conv("R4 -inf narrow", 64'hFFF0000000000000, 1, 0, 2, 0, S32, IV);
    conv("R4 nanf wide", 64'h000000007FC00000, 0, 1, 1, 0, S64, IV);
    conv("R4 -inff narrow", 64'h00000000FF800000, 0, 0, 4, 0, S32, IV);
  endtask

  task automatic t_overflow;
    conv("R5 2^31 narrow", 64'h41E0000000000000, 1, 0, 0, 0, S32, OV);
    conv("R5 -2^31 narrow", 64'hC1E0000000000000, 1, 0, 0, 0, 64'hFFFF_FFFF_8000_0000, NO);
    conv("R5 2^31 wide", 64'h41E0000000000000, 1, 1, 0, 0, 64'h0000_0000_8000_0000, NO);
    conv("R5 2^63 wide", 64'h43E0000000000000, 1, 1, 2, 0, S64, OV);
    conv("R5 -2^63 wide", 64'hC3E0000000000000, 1, 1, 0, 0, 64'h8000_0000_0000_0000, NO);
    conv("R5 max+.5 round", 64'h41DFFFFFFFE00000, 1, 0, 1, 0, S32, OV);
    conv("R5 max+.5 trunc", 64'h41DFFFFFFFE00000, 1, 0, 2, 0, S32, IX);
    conv("R5 min-.5 floor", 64'hC1E0000000100000, 1, 0, 4, 0, S32, OV);
    conv("R5 min-.5 ceil", 64'hC1E0000000100000, 1, 0, 3, 0, 64'hFFFF_FFFF_8000_0000, IX);
    conv("R5 2^32f narrow", 64'h000000004F800000, 0, 0, 0, 0, S32, OV);
    conv("R5 2^32f wide", 64'h000000004F800000, 0, 1, 0, 0, 64'h0000_0001_0000_0000, NO);
  endtask

  task automatic t_exact;
    conv("R6 1.0 exact", 64'h3FF0000000000000, 1, 0, 4, 2, 64'd1, NO);
    conv("R6 1e10 exact", 64'h4202A05F20000000, 1, 1, 2, 0, 64'h0000_0002_540B_E400, NO);
    conv("R6 +0", 64'h0000000000000000, 1, 1, 3, 0, 64'd0, NO);
    conv("R6 -0", 64'h8000000000000000, 1, 1, 4, 0, 64'd0, NO);
  endtask

  task automatic t_denormal;
    conv("R7 sub round", 64'h0000000000000001, 1, 1, 1, 0, 64'd0, IX);
    conv("R7 sub ceil", 64'h0000000000000001, 1, 1, 3, 0, 64'd1, IX);
    conv("R7 sub floor", 64'h0000000000000001, 1, 1, 4, 0, 64'd0, IX);
    conv("R7 -sub floor", 64'h8000000000000001, 1, 1, 4, 0, 64'hFFFF_FFFF_FFFF_FFFF, IX);
    conv("R7 subf ceil", 64'h0000000000000001, 0, 0, 3, 0, 64'd1, IX);
    conv("R7 -subf rm0", 64'h0000000080000001, 0, 0, 0, 0, 64'd0, IX);
  endtask

  task automatic t_single;
    conv("R8 2.5f junk upper", 64'hDEADBEEF40200000, 0, 0, 1, 0, 64'd2, IX);
    conv("R8 2.5f ceil junk", 64'hFFFFFFFF40200000, 0, 1, 3, 0, 64'd3, IX);
  endtask

  task automatic t_width;
    conv("R9 floor -2.5 narrow", 64'hC004000000000000, 1, 0, 4, 0, 64'hFFFF_FFFF_FFFF_FFFD, IX);
    conv("R9 3.5 narrow", 64'h400C000000000000, 1, 0, 3, 0, 64'd4, IX);
  endtask

  task automatic t_handshake;
    conv("R10 setup", 64'h4004000000000000, 1, 1, 3, 0, 64'd3, IX);
    in_operand = 64'h7FF0000000000000;
    @(negedge clk);
    check("R10 idle valid", {63'd0, out_valid}, 64'd0);
    check("R10 idle hold", out_result, 64'd3);
    check("R10 idle flags", {61'd0, out_inexact, out_overflow, out_invalid}, {61'd0, IX});
  endtask

  task automatic t_no_carry;
    conv("R11 trunc rm2", 64'h3FF8000000000000, 1, 1, 2, 2, 64'd1, IX);
    conv("R11 convert rm2", 64'h3FF8000000000000, 1, 1, 0, 2, 64'd2, IX);
    conv("R11 floor rm0", 64'h3FF8000000000000, 1, 1, 4, 0, 64'd1, IX);
    conv("R11 convert rm0", 64'h3FF8000000000000, 1, 1, 0, 0, 64'd2, IX);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_convert_modes();
    t_round();
    t_directed();
    t_invalid();
    t_overflow();
    t_exact();
    t_denormal();
    t_single();
    t_width();
    t_handshake();
    t_no_carry();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule